// File: doc/BRIEF.md
# Single-Wire Diagnostic Serial Mode Controller

This block manages a two-wire diagnostic link made of an active-low request line and a shared, open-drain fail line. When nobody is asking for anything, the fail line simply shows the masked fault indicator. When the request line is pulled low, the block lets the fail line go high and asks the fault register block to take a snapshot. It then watches the fail line while the request stays low. When the request is released, it picks one of three jobs: send the snapshot, send a self-test result, or accept a new reporting mask and echo it back.

All traffic on the fail line uses asynchronous frames. Each frame has one low start bit, eight data bits with bit 0 first, and one high stop bit. Every bit lasts sixteen ticks of an oversampling clock. The block can only pull the fail line low; it never drives it high. Its receiver is switched off whenever the block is transmitting, so it never decodes its own bits. Pad electrics and the storage for the fault register and the mask live outside this block.

Top module: `diag_serial_ctrl`

## Requirements
- R1: While reset is held and right after it is released, the block is idle. Every strobe (`snap_stb`, `st_start`, `mask_wr`) is low, and `fail_pull` equals `fault_ind`.
- R2: In idle, the fail line is the static fault indicator: `fail_pull` follows `fault_ind`.
- R3: When the request line falls in idle, `snap_stb` pulses once and `fail_pull` drops to 0 by the next cycle. It stays 0 as long as the request is held.
- R4: Every transmitted frame is built as follows. One low start bit comes first. The 8 data bits follow, least significant bit first. One high stop bit ends the frame. Each bit lasts 16·`OSR_DIV` clocks. On the line, low means `fail_pull`=1.
- R5: FIR read: the request is held low for at least `HOLD_CYC` cycles, with no self-test hold and no frame. When it rises, `fir_data` is transmitted, with the start bit beginning within 3 cycles.
- R6: A request held low for fewer than `HOLD_CYC` cycles produces no transmission. The block then returns to idle.
- R7: Self-test: the fail line is forced low for `HOLD_CYC` consecutive cycles before the receiver has armed. This gives exactly one `st_start` pulse. When the request rises, `st_data` is transmitted.
- R8: Programming: a frame completes with its start bit low at mid-bit and its stop bit high. When the request rises, `mask_wr` pulses once with `mask_data` equal to the received byte, and that byte is echoed. `mask_wr` never pulses while the request is low.
- R9: A completed frame whose start bit is not low at mid-bit, or whose stop bit is not high, is invalid. It causes no `mask_wr`, and the unchanged `mask_cur` is transmitted.
- R10: Any completed frame, including one whose verdict falls in the same cycle as the request rise, selects programming. It takes precedence over self-test and FIR read. A frame that has not finished when the request rises is dropped, and FIR read applies.
- R11: During a transmission, the request line is ignored. After the stop bit the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n | input | 1 | Synchronised request line, active low |
| fail_in | input | 1 | Sensed level of the fail line (asynchronous) |
| fault_ind | input | 1 | Masked fault present; shown on the line in idle |
| fir_data | input | 8 | Snapshot contents to send on FIR read |
| st_data | input | 8 | Self-test result to send |
| mask_cur | input | 8 | Current reporting mask |
| fail_pull | output | 1 | Open-drain pull-down enable for the fail line |
| snap_stb | output | 1 | One-cycle snapshot strobe |
| st_start | output | 1 | One-cycle self-test start strobe |
| mask_wr | output | 1 | One-cycle mask write strobe |
| mask_data | output | 8 | New mask value, valid with `mask_wr` |

## Verification
Two things can fall in the same cycle. One is the receiver's stop-bit verdict on a programming frame. The other is the cycle in which the controller samples the request rise and chooses the mode. The bench sends a frame and releases the request at a sweep of offsets inside the stop bit, so that some rises land before the verdict, some on it, and some after it. In each case the result must be all or nothing. Either the received byte is echoed together with exactly one `mask_wr`, or the snapshot byte is sent with no `mask_wr`. A mixed outcome counts as a miscompare.

// File: rtl/diag_serial_pkg.sv
`timescale 1ns/1ps
// Shared types for the diagnostic serial controller.
// Assumes: nothing beyond standard SystemVerilog.
package diag_serial_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_TX} ctrl_state_t;
    localparam int unsigned OSR = 16;       // ticks per bit
    localparam int unsigned MID_TICK = 7;   // start-bit centre tick index
endpackage

// File: rtl/diag_tick_gen.sv
`timescale 1ns/1ps
// Oversampling tick generator: one-cycle pulse every DIV clocks.
// Assumes: DIV >= 1; free running after reset.
module diag_tick_gen #(
    parameter int unsigned DIV = 1302
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    logic [CW-1:0] cnt;

    // Divide the clock down to the oversampling rate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/diag_uart_tx.sv
`timescale 1ns/1ps
// 8N1 transmitter; line=1 means released (high), line=0 means pulled low.
// Assumes: start is a one-cycle pulse presented only while busy is low.
module diag_uart_tx
    import diag_serial_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic [7:0] data,
    output logic       busy,
    output logic       line
);
    logic [9:0] shreg;
    logic [3:0] tcnt;
    logic [3:0] bidx;

    // Load a frame and shift one bit out every OSR ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            tcnt  <= '0;
            bidx  <= '0;
            busy  <= 1'b0;
        end else if (start && !busy) begin
            shreg <= {1'b1, data, 1'b0};
            tcnt  <= '0;
            bidx  <= '0;
            busy  <= 1'b1;
        end else if (busy && tick) begin
            if (tcnt == 4'(OSR - 1)) begin
                tcnt  <= '0;
                shreg <= {1'b1, shreg[9:1]};
                if (bidx == 4'd9) busy <= 1'b0;
                else              bidx <= bidx + 1'b1;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    assign line = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/diag_uart_rx.sv
`timescale 1ns/1ps
// 8N1 receiver with 16x oversampling; takes one frame per enable period.
// Assumes: line is already synchronised; en low discards any partial frame.
// Arms only after seeing the line high, so a held-low line is not a start.
module diag_uart_rx
    import diag_serial_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       line,
    output logic       armed,
    output logic       done,
    output logic       ok,
    output logic [7:0] data
);
    typedef enum logic [2:0] {R_WAIT_HI, R_IDLE, R_START, R_DATA, R_STOP, R_HOLD} rx_state_t;
    rx_state_t  rs;
    logic [3:0] tcnt;
    logic [2:0] bidx;
    logic       start_good;

    // Walk the frame, sampling each bit at its centre.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs <= R_WAIT_HI; tcnt <= '0; bidx <= '0;
            start_good <= 1'b0; done <= 1'b0; ok <= 1'b0; data <= '0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                rs <= R_WAIT_HI;
            end else if (tick) begin
                case (rs)
                    R_WAIT_HI: if (line) rs <= R_IDLE;
                    R_IDLE: if (!line) begin rs <= R_START; tcnt <= '0; end
                    R_START: begin
                        if (tcnt == 4'(MID_TICK)) begin
                            start_good <= !line;
                            tcnt <= '0; bidx <= '0; rs <= R_DATA;
                        end else tcnt <= tcnt + 1'b1;
                    end
                    R_DATA: begin
                        if (tcnt == 4'(OSR - 1)) begin
                            data <= {line, data[7:1]};
                            tcnt <= '0;
                            if (bidx == 3'd7) rs <= R_STOP;
                            else              bidx <= bidx + 1'b1;
                        end else tcnt <= tcnt + 1'b1;
                    end
                    R_STOP: begin
                        if (tcnt == 4'(OSR - 1)) begin
                            ok   <= start_good && line;
                            done <= 1'b1;
                            rs   <= R_HOLD;
                        end else tcnt <= tcnt + 1'b1;
                    end
                    default: rs <= R_HOLD;
                endcase
            end
        end
    end

    assign armed = (rs != R_WAIT_HI);
endmodule

// File: rtl/diag_serial_ctrl.sv
`timescale 1ns/1ps
// Diagnostic serial mode controller (top).
// Decodes the request/fail-line protocol into FIR read, self-test or mask
// programming, and answers with one 8N1 frame on the open-drain fail line.
// Assumes: req_n is already synchronous; fail_in is asynchronous; st_data
// is valid by the time the request rises after st_start.
module diag_serial_ctrl
    import diag_serial_pkg::*;
#(
    parameter int unsigned OSR_DIV  = 1302,  // clocks per oversampling tick
    parameter int unsigned HOLD_CYC = 4000   // minimum hold time in clocks
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_n,
    input  logic       fail_in,
    input  logic       fault_ind,
    input  logic [7:0] fir_data,
    input  logic [7:0] st_data,
    input  logic [7:0] mask_cur,
    output logic       fail_pull,
    output logic       snap_stb,
    output logic       st_start,
    output logic       mask_wr,
    output logic [7:0] mask_data
);
    localparam int unsigned HW = $clog2(HOLD_CYC + 1);

    ctrl_state_t st;
    logic          fail_meta, fail_s;
    logic [HW-1:0] hold_cnt, low_cnt;
    logic          hold_done, st_seen, frame_seen, frame_ok;
    logic          tick, tx_start, tx_busy, tx_line;
    logic [7:0]    tx_byte;
    logic          rx_armed, rx_done, rx_ok;
    logic [7:0]    rx_data;
    logic          pick_frame, pick_ok;

    assign hold_done  = (hold_cnt == HW'(HOLD_CYC));
    assign pick_frame = frame_seen || rx_done;
    assign pick_ok    = frame_seen ? frame_ok : rx_ok;

    diag_tick_gen #(.DIV(OSR_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

    diag_uart_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(tx_start),
        .data(tx_byte), .busy(tx_busy), .line(tx_line)
    );

    diag_uart_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .en(st == ST_REQ && hold_done), .line(fail_s),
        .armed(rx_armed), .done(rx_done), .ok(rx_ok), .data(rx_data)
    );

    // Two-flop synchroniser for the sensed fail line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_meta <= 1'b1;
            fail_s    <= 1'b1;
        end else begin
            fail_meta <= fail_in;
            fail_s    <= fail_meta;
        end
    end

    // Mode controller: request tracking, mode choice and frame launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
            hold_cnt <= '0; low_cnt <= '0;
            st_seen <= 1'b0; frame_seen <= 1'b0; frame_ok <= 1'b0;
            snap_stb <= 1'b0; st_start <= 1'b0; mask_wr <= 1'b0;
            mask_data <= '0; tx_start <= 1'b0; tx_byte <= '0;
        end else begin
            snap_stb <= 1'b0;
            st_start <= 1'b0;
            mask_wr  <= 1'b0;
            tx_start <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (!req_n) begin
                        st <= ST_REQ;
                        snap_stb <= 1'b1;
                        hold_cnt <= '0; low_cnt <= '0;
                        st_seen <= 1'b0; frame_seen <= 1'b0; frame_ok <= 1'b0;
                    end
                end
                ST_REQ: begin
                    if (!hold_done) hold_cnt <= hold_cnt + 1'b1;
                    if (!rx_armed) begin
                        if (fail_s)                       low_cnt <= '0;
                        else if (low_cnt != HW'(HOLD_CYC)) low_cnt <= low_cnt + 1'b1;
                        if (low_cnt == HW'(HOLD_CYC) && !st_seen) begin
                            st_seen  <= 1'b1;
                            st_start <= 1'b1;
                        end
                    end
                    if (rx_done) begin
                        frame_seen <= 1'b1;
                        frame_ok   <= rx_ok;
                    end
                    if (req_n) begin
                        if (pick_frame) begin
                            tx_byte   <= pick_ok ? rx_data : mask_cur;
                            mask_wr   <= pick_ok;
                            if (pick_ok) mask_data <= rx_data;
                            tx_start  <= 1'b1;
                            st        <= ST_TX;
                        end else if (st_seen) begin
                            tx_byte  <= st_data;
                            tx_start <= 1'b1;
                            st       <= ST_TX;
                        end else if (hold_done) begin
                            tx_byte  <= fir_data;
                            tx_start <= 1'b1;
                            st       <= ST_TX;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    if (!tx_start && !tx_busy) st <= ST_IDLE;
                end
            endcase
        end
    end

    // Open-drain drive: fault indicator, released, or transmitted bit.
    always_comb begin
        case (st)
            ST_IDLE: fail_pull = fault_ind;
            ST_REQ:  fail_pull = 1'b0;
            default: fail_pull = !tx_line;
        endcase
    end
endmodule

// File: rtl/diag_serial_ctrl_checker.sv
`timescale 1ns/1ps
// Protocol checker for diag_serial_ctrl, attached by bind.
// Assumes: sampled on the rising clock; reset is synchronous active-low.
module diag_serial_ctrl_checker
    import diag_serial_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_n,
    input logic        fail_pull,
    input logic        snap_stb,
    input logic        st_start,
    input logic        mask_wr,
    input ctrl_state_t st_q,
    input logic        hold_done,
    input logic        tx_busy
);
    // R3: a request fall in idle snapshots and releases the line next cycle.
    p_release_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !req_n) |=> (snap_stb && !fail_pull));

    // R8: strobes never coincide.
    p_strobes_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({snap_stb, st_start, mask_wr}));

    // R8: mask write only follows a released request.
    p_mask_wr_after_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |-> $past(req_n));

    // R5: a rise after a full hold always launches a frame.
    p_tx_after_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_REQ && req_n && hold_done) |=> (st_q == ST_TX));

    // R6: a short request returns to idle without a mask write.
    p_short_req_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_REQ && req_n && !hold_done) |=> (st_q == ST_IDLE && !mask_wr));

    // R7: self-test start is a single-cycle pulse.
    p_selftest_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_start |=> !st_start);

    // R11: the transmitter stays busy while a frame is going out after launch.
    p_tx_busy_in_tx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TX && $past(st_q) == ST_TX) |-> (tx_busy || $past(tx_busy)));
endmodule

bind diag_serial_ctrl diag_serial_ctrl_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .fail_pull(fail_pull),
    .snap_stb(snap_stb), .st_start(st_start), .mask_wr(mask_wr),
    .st_q(st), .hold_done(hold_done), .tx_busy(tx_busy)
);

// File: tb/diag_serial_ctrl_bench.sv
`timescale 1ns/1ps
// Self-checking bench: vector table walk, then directed corner cases.
module diag_serial_ctrl_bench;
    localparam int OSR_DIV  = 2;
    localparam int HOLD_CYC = 40;
    localparam int BIT      = 16 * OSR_DIV;

    // kind: 0 FIR read, 1 self-test, 2 program good frame, 3 program bad stop
    typedef struct packed {
        logic [1:0] kind;
        logic [7:0] ub;
        logic [7:0] fir;
        logic [7:0] st;
        logic [7:0] seed;
        logic [7:0] exp;
        logic       mw;
        logic       stx;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'h00, 8'hA5, 8'h00, 8'h11, 8'hA5, 1'b0, 1'b0},
        '{2'd0, 8'h00, 8'h01, 8'h00, 8'h11, 8'h01, 1'b0, 1'b0},
        '{2'd1, 8'h00, 8'h99, 8'h3C, 8'h11, 8'h3C, 1'b0, 1'b1},
        '{2'd2, 8'h5A, 8'h99, 8'h00, 8'h0F, 8'h5A, 1'b1, 1'b0},
        '{2'd2, 8'h00, 8'h99, 8'h00, 8'hF0, 8'h00, 1'b1, 1'b0},
        '{2'd3, 8'h77, 8'h99, 8'h00, 8'hC3, 8'hC3, 1'b0, 1'b0},
        '{2'd2, 8'hFF, 8'h99, 8'h00, 8'h12, 8'hFF, 1'b1, 1'b0},
        '{2'd1, 8'h00, 8'h66, 8'h80, 8'h11, 8'h80, 1'b0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_n = 1'b1;
    logic       user_pull = 1'b0;
    logic       fault_ind = 1'b0;
    logic [7:0] fir_data = '0;
    logic [7:0] st_data = '0;
    logic [7:0] mask_cur;
    logic [7:0] mask_seed = '0;
    logic       mask_load = 1'b0;
    logic       fail_in, fail_pull, snap_stb, st_start, mask_wr;
    logic [7:0] mask_data;

    int n_chk = 0, n_bad = 0;
    int n_snap = 0, n_st = 0, n_mw = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign fail_in = ~(fail_pull | user_pull);

    diag_serial_ctrl #(.OSR_DIV(OSR_DIV), .HOLD_CYC(HOLD_CYC)) u_diag_serial_ctrl (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .fail_in(fail_in),
        .fault_ind(fault_ind), .fir_data(fir_data), .st_data(st_data),
        .mask_cur(mask_cur), .fail_pull(fail_pull), .snap_stb(snap_stb),
        .st_start(st_start), .mask_wr(mask_wr), .mask_data(mask_data)
    );

    // Model of the external mask register and strobe counters.
    always @(posedge clk) begin
        if (mask_wr)        mask_cur <= mask_data;
        else if (mask_load) mask_cur <= mask_seed;
        if (rst_n) begin
            if (snap_stb) n_snap <= n_snap + 1;
            if (st_start) n_st   <= n_st + 1;
            if (mask_wr)  n_mw   <= n_mw + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_mask(input logic [7:0] v);
        mask_seed = v; mask_load = 1'b1;
        clks(1);
        mask_load = 1'b0;
        clks(1);
    endtask

    // User side frame; stop_len clocks of stop, stop level chosen by bad_stop.
    task automatic send_byte(input logic [7:0] b, input bit bad_stop, input int stop_len);
        user_pull = 1'b1; clks(BIT);
        for (int i = 0; i < 8; i++) begin
            user_pull = ~b[i]; clks(BIT);
        end
        user_pull = bad_stop; clks(stop_len);
        user_pull = 1'b0;
    endtask

    // Decode one frame from the block's pull-down output.
    task automatic get_frame(output logic [7:0] b, output logic stop_ok, output logic seen);
        seen = 1'b0; b = '0; stop_ok = 1'b0;
        for (int i = 0; i < 300 && !seen; i++) begin
            clks(1);
            if (fail_pull) seen = 1'b1;
        end
        if (seen) begin
            clks(BIT / 2);
            for (int k = 0; k < 8; k++) begin
                clks(BIT);
                b[k] = ~fail_pull;
            end
            clks(BIT);
            stop_ok = ~fail_pull;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] got;
        logic       sok, seen;
        int         s0, t0, w0;
        bit         any_pull;

        // R1: reset state
        fault_ind = 1'b1;
        clks(4);
        check(fail_pull == 1'b1, "R1 reset pull", fail_pull, 1);
        check({snap_stb, st_start, mask_wr} == 3'b000, "R1 reset strobes",
              {snap_stb, st_start, mask_wr}, 0);
        rst_n = 1'b1;
        clks(2);
        fault_ind = 1'b0;
        clks(1);
        check(fail_pull == 1'b0, "R1 after reset", fail_pull, 0);

        // R2: idle mirror
        fault_ind = 1'b1; clks(1);
        check(fail_pull == 1'b1, "R2 idle fault on", fail_pull, 1);
        fault_ind = 1'b0; clks(1);
        check(fail_pull == 1'b0, "R2 idle fault off", fail_pull, 0);

        // R3: release on request fall, even with a fault shown
        fault_ind = 1'b1; clks(1);
        s0 = n_snap;
        req_n = 1'b0; clks(2);
        check(fail_pull == 1'b0, "R3 released", fail_pull, 0);
        check(n_snap - s0 == 1, "R3 snapshot", n_snap - s0, 1);
        // R6: short request, no transmission
        clks(5);
        req_n = 1'b1;
        fault_ind = 1'b0;
        any_pull = 1'b0;
        for (int i = 0; i < 3 * BIT; i++) begin
            clks(1);
            if (fail_pull) any_pull = 1'b1;
        end
        check(!any_pull, "R6 short request silent", any_pull, 0);

        // Vector table: FIR, self-test, programming good/bad (R4,R5,R7,R8,R9)
        for (int v = 0; v < NV; v++) begin
            fir_data = VECS[v].fir;
            st_data  = VECS[v].st;
            load_mask(VECS[v].seed);
            t0 = n_st; w0 = n_mw;
            req_n = 1'b0;
            case (VECS[v].kind)
                2'd0: clks(HOLD_CYC + 10);
                2'd1: begin
                    clks(3); user_pull = 1'b1;
                    clks(HOLD_CYC + 10); user_pull = 1'b0;
                    clks(5);
                end
                default: begin
                    clks(HOLD_CYC + 10);
                    send_byte(VECS[v].ub, VECS[v].kind == 2'd3, BIT);
                    clks(5);
                end
            endcase
            req_n = 1'b1;
            get_frame(got, sok, seen);
            check(seen && got == VECS[v].exp, $sformatf("R5/R7/R8/R9 vec%0d byte", v),
                  got, VECS[v].exp);
            check(sok, $sformatf("R4 vec%0d stop bit", v), sok, 1);
            check(n_mw - w0 == int'(VECS[v].mw), $sformatf("R8/R9 vec%0d mask_wr", v),
                  n_mw - w0, VECS[v].mw);
            check(n_st - t0 == int'(VECS[v].stx), $sformatf("R7 vec%0d st_start", v),
                  n_st - t0, VECS[v].stx);
            clks(BIT);
            if (VECS[v].kind >= 2'd2)
                check(mask_cur == VECS[v].exp, $sformatf("R8/R9 vec%0d mask", v),
                      mask_cur, VECS[v].exp);
        end

        // R11: request activity during a transmission is ignored
        fir_data = 8'h4B;
        req_n = 1'b0; clks(HOLD_CYC + 5); req_n = 1'b1;
        clks(1);
        s0 = n_snap;
        fork
            get_frame(got, sok, seen);
            begin
                clks(3 * BIT);
                req_n = 1'b0; clks(6); req_n = 1'b1;
            end
        join
        check(seen && got == 8'h4B, "R11 frame intact", got, 8'h4B);
        check(n_snap - s0 == 0, "R11 request ignored", n_snap - s0, 0);
        clks(BIT);
        fault_ind = 1'b1; clks(1);
        check(fail_pull == 1'b1, "R11 back to idle", fail_pull, 1);
        fault_ind = 1'b0; clks(1);

        // R10: request rise swept across the stop-bit verdict
        for (int off = BIT / 2 - 4; off <= BIT / 2 + 8; off += 2) begin
            fir_data = 8'hE1;
            load_mask(8'h00);
            w0 = n_mw;
            req_n = 1'b0; clks(HOLD_CYC + 10);
            send_byte(8'h3E, 1'b0, off);
            req_n = 1'b1;
            get_frame(got, sok, seen);
            check(seen && ((got == 8'h3E && n_mw - w0 == 1) ||
                           (got == 8'hE1 && n_mw - w0 == 0)),
                  $sformatf("R10 rise offset %0d", off), got, 8'h3E);
            clks(2 * BIT);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule